// File: doc/BRIEF.md
# PHY Extender Sublayer Management Register Bank

This block holds the management state of a 10-gigabit PHY extender sublayer. A simple parallel access port reaches it: an address, a write strobe with write data, and a read strobe. The read strobe returns registered data one cycle later. Three registers are mapped. The control word at address 0 carries the self-clearing device reset request and the loopback enable. The link status word at address 1 carries the transmit-link-up flag and a local-fault summary. The presence/fault word at address 8 carries a fixed presence code and two sticky local-fault flags.

Live condition inputs feed the sticky status bits. These inputs are per-lane signal-level and byte-sync flags, a lane-alignment flag and a PLL-lock flag. The link-up flag falls on any transmit-side problem and stays low until the status word is read. The two fault flags rise on a problem and stay high until the fault word is read, or until an alarm-register read is reported on a strobe. A clear or re-arm takes effect only if the underlying condition has gone away. Writing the reset bit produces a fixed-length reset pulse. While that pulse is active, every management bit is held at its default.

Top module: `phyxs_regbank`

## Requirements
- R1: After `rst_n` is released, `chip_reset` and `loopback_en` are 0 and `rd_data` is 0. A read of address 0 returns 0x2040, a read of address 1 returns 0x0004, and a read of address 8 returns 0x8000.
- R2: A write of address 0 with bit 15 set, made while no pulse is active, raises `chip_reset` in the cycle after the write. It holds `chip_reset` high for exactly RST_CYC cycles (4 by default). Bit 15 of address 0 reads 1 while the pulse is active. The pulse returns loopback to 0, the link-up flag to 1 and both fault flags to 0.
- R3: Bit 14 of address 0 is read/write and drives every bit of `loopback_en`.
- R4: In the word at address 0, bits 13 and 6 read 1 and all other bits except 15 and 14 read 0, whatever is written. Writes to addresses 1 and 8 change nothing.
- R5: The transmit-side condition is good when every lane has both signal-level and byte-sync flags high and `lane_align` is high. Bit 2 of address 1 latches to 0 at any clock edge where the condition is bad. A read of address 1 loads it with the present condition. Otherwise it stays at 0.
- R6: Bit 7 of address 1 reads the OR of bits 11 and 10 of address 8. Bit 1 and all other unnamed bits of address 1 read 0.
- R7: Bits 15:14 of address 8 always read binary 10.
- R8: Bit 11 of address 8 latches to 1 when the transmit-side condition is bad. Bit 10 latches to 1 when `pll_locked` is low. Both hold until cleared.
- R9: A read of address 8, or a pulse on `alarm_rd_stb`, loads bits 11 and 10 with their present fault conditions. A bit therefore clears only if its fault has gone.
- R10: `rd_data` updates at the clock edge that samples `rd_en` and holds between reads. It shows register contents from before any clear or re-arm caused by that same read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| alarm_rd_stb | input | 1 | Alarm-register read occurred; clears fault flags |
| sig_ok | input | NUM_LANES | Per-lane signal level good |
| byte_sync | input | NUM_LANES | Per-lane byte synchronisation achieved |
| lane_align | input | 1 | Lane-to-lane alignment achieved |
| pll_locked | input | 1 | Receive PLL locked |
| chip_reset | output | 1 | Self-clearing device reset pulse |
| loopback_en | output | NUM_LANES | Loopback enable per lane |

## Verification
Every result of a read appears on `rd_data` one clock after the edge that samples `rd_en`. The bench drives each stimulus on a falling edge and compares at the next falling edge, so exactly one register stage lies between the two. A condition input sampled at an edge affects the sticky bits at that same edge, so the first read that can observe it is issued on the following cycle. The reset pulse is due in the cycle after the write edge and is checked on each of the following five falling edges: four high samples, then one low.

// File: rtl/phyxs_pkg.sv
package phyxs_pkg;
   localparam int REG_W      = 16;
   localparam int ADR_CTRL   = 0;
   localparam int ADR_LINK   = 1;
   localparam int ADR_FAULT  = 8;
   localparam int B_RST      = 15;
   localparam int B_LPBK     = 14;
   localparam int B_SPD_HI   = 13;
   localparam int B_SPD_LO   = 6;
   localparam int B_LFAULT   = 7;
   localparam int B_TXUP     = 2;
   localparam int B_TXFLT    = 11;
   localparam int B_RXFLT    = 10;
   localparam logic [1:0] PRESENT_CODE = 2'b10;

   typedef struct packed {
      logic rst_busy;
      logic lpbk;
      logic tx_up;
      logic tx_flt;
      logic rx_flt;
   } mgmt_view_t;
endpackage

// File: rtl/phyxs_ctl_reg.sv
module phyxs_ctl_reg #(
   parameter int RST_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic wr_rst_bit,
   input  logic wr_lpbk_bit,
   output logic rst_busy,
   output logic soft_rst,
   output logic lpbk_q
);
   localparam int CNT_W = $clog2(RST_CYC + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             start;

   assign rst_busy = (cnt_q != '0);
   assign start    = wr_stb & wr_rst_bit & ~rst_busy;
   assign soft_rst = start | rst_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CNT_W'(RST_CYC);
      end else if (rst_busy) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lpbk_q <= 1'b0;
      end else if (soft_rst) begin
         lpbk_q <= 1'b0;
      end else if (wr_stb) begin
         lpbk_q <= wr_lpbk_bit;
      end
   end
endmodule

// File: rtl/phyxs_lane_cond.sv
module phyxs_lane_cond #(
   parameter int NUM_LANES = 4
) (
   input  logic [NUM_LANES-1:0] sig_ok,
   input  logic [NUM_LANES-1:0] byte_sync,
   input  logic                 lane_align,
   input  logic                 pll_locked,
   output logic                 tx_bad,
   output logic                 rx_bad
);
   logic [NUM_LANES-1:0] lane_ok;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      assign lane_ok[i] = sig_ok[i] & byte_sync[i];
   end

   assign tx_bad = ~((&lane_ok) & lane_align);
   assign rx_bad = ~pll_locked;
endmodule

// File: rtl/phyxs_sticky_bit.sv
module phyxs_sticky_bit #(
   parameter bit HOLD_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic bad,
   input  logic rearm,
   output logic q
);
   localparam logic IDLE_VAL = HOLD_HIGH ? 1'b0 : 1'b1;

   logic nxt;

   if (HOLD_HIGH) begin : g_hold_high
      always_comb nxt = rearm ? bad : (q | bad);
   end else begin : g_hold_low
      always_comb nxt = rearm ? ~bad : (q & ~bad);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= IDLE_VAL;
      end else if (soft_rst) begin
         q <= IDLE_VAL;
      end else begin
         q <= nxt;
      end
   end
endmodule

// File: rtl/phyxs_rd_mux.sv
module phyxs_rd_mux
   import phyxs_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  mgmt_view_t        view,
   output logic [REG_W-1:0]  data
);
   logic [REG_W-1:0] ctrl_w, link_w, flt_w;

   always_comb begin
      ctrl_w           = '0;
      ctrl_w[B_RST]    = view.rst_busy;
      ctrl_w[B_LPBK]   = view.lpbk;
      ctrl_w[B_SPD_HI] = 1'b1;
      ctrl_w[B_SPD_LO] = 1'b1;

      link_w           = '0;
      link_w[B_LFAULT] = view.tx_flt | view.rx_flt;
      link_w[B_TXUP]   = view.tx_up;

      flt_w            = '0;
      flt_w[15:14]     = PRESENT_CODE;
      flt_w[B_TXFLT]   = view.tx_flt;
      flt_w[B_RXFLT]   = view.rx_flt;
   end

   always_comb begin
      if (addr == ADDR_W'(ADR_CTRL))       data = ctrl_w;
      else if (addr == ADDR_W'(ADR_LINK))  data = link_w;
      else if (addr == ADDR_W'(ADR_FAULT)) data = flt_w;
      else                                 data = '0;
   end
endmodule

// File: rtl/phyxs_regbank.sv
module phyxs_regbank
   import phyxs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int NUM_LANES = 4,
   parameter int RST_CYC   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_en,
   input  logic [15:0]          wr_data,
   input  logic                 rd_en,
   output logic [15:0]          rd_data,
   input  logic                 alarm_rd_stb,
   input  logic [NUM_LANES-1:0] sig_ok,
   input  logic [NUM_LANES-1:0] byte_sync,
   input  logic                 lane_align,
   input  logic                 pll_locked,
   output logic                 chip_reset,
   output logic [NUM_LANES-1:0] loopback_en
);
   if (ADDR_W < 4) begin : g_chk_aw
      $error("ADDR_W must reach address 8");
   end
   if (NUM_LANES < 1) begin : g_chk_ln
      $error("NUM_LANES must be at least 1");
   end
   if (RST_CYC < 1) begin : g_chk_rc
      $error("RST_CYC must be at least 1");
   end

   logic wr_ctrl, rd_link, rd_flt, flt_rearm;
   logic soft_rst, lpbk_q, tx_bad, rx_bad;
   logic tx_up_q, tx_flt_q, rx_flt_q;
   logic [REG_W-1:0] mux_data;
   mgmt_view_t view;
   logic unused_wdata;

   assign unused_wdata = ^wr_data[13:0];
   assign wr_ctrl   = wr_en & (addr == ADDR_W'(ADR_CTRL));
   assign rd_link   = rd_en & (addr == ADDR_W'(ADR_LINK));
   assign rd_flt    = rd_en & (addr == ADDR_W'(ADR_FAULT));
   assign flt_rearm = rd_flt | alarm_rd_stb;

   phyxs_ctl_reg #(.RST_CYC(RST_CYC)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (wr_ctrl),
      .wr_rst_bit (wr_data[B_RST]),
      .wr_lpbk_bit(wr_data[B_LPBK]),
      .rst_busy   (chip_reset),
      .soft_rst   (soft_rst),
      .lpbk_q     (lpbk_q)
   );

   phyxs_lane_cond #(.NUM_LANES(NUM_LANES)) u_cond (
      .sig_ok    (sig_ok),
      .byte_sync (byte_sync),
      .lane_align(lane_align),
      .pll_locked(pll_locked),
      .tx_bad    (tx_bad),
      .rx_bad    (rx_bad)
   );

   phyxs_sticky_bit #(.HOLD_HIGH(1'b0)) u_tx_up (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .bad(tx_bad), .rearm(rd_link), .q(tx_up_q)
   );

   phyxs_sticky_bit #(.HOLD_HIGH(1'b1)) u_tx_flt (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .bad(tx_bad), .rearm(flt_rearm), .q(tx_flt_q)
   );

   phyxs_sticky_bit #(.HOLD_HIGH(1'b1)) u_rx_flt (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .bad(rx_bad), .rearm(flt_rearm), .q(rx_flt_q)
   );

   assign view = '{rst_busy: chip_reset, lpbk: lpbk_q, tx_up: tx_up_q,
                   tx_flt: tx_flt_q, rx_flt: rx_flt_q};

   phyxs_rd_mux #(.ADDR_W(ADDR_W)) u_mux (
      .addr(addr),
      .view(view),
      .data(mux_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= mux_data;
      end
   end

   assign loopback_en = {NUM_LANES{lpbk_q}};
endmodule

// File: rtl/phyxs_regbank_chk.sv
module phyxs_regbank_chk #(
   parameter int ADDR_W    = 16,
   parameter int NUM_LANES = 4,
   parameter int RST_CYC   = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    addr,
   input logic                 wr_en,
   input logic [15:0]          wr_data,
   input logic                 rd_en,
   input logic [15:0]          rd_data,
   input logic                 alarm_rd_stb,
   input logic                 chip_reset,
   input logic [NUM_LANES-1:0] loopback_en,
   input logic                 tx_bad,
   input logic                 rx_bad,
   input logic                 tx_up_q,
   input logic                 tx_flt_q,
   input logic                 rx_flt_q
);
   logic [31:0] hi_cnt;
   logic        rst_req;

   assign rst_req = wr_en && (addr == ADDR_W'(0)) && wr_data[15];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hi_cnt <= '0;
      else if (chip_reset) hi_cnt <= hi_cnt + 1;
      else                 hi_cnt <= '0;
   end

   p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chip_reset) |-> hi_cnt == 32'(RST_CYC));

   p_pulse_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !chip_reset) |=> chip_reset);

   p_lpbk_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chip_reset |-> loopback_en == '0);

   p_txup_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bad && !chip_reset && !rst_req) |=> !tx_up_q);

   p_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(8)) |=> rd_data[15:14] == 2'b10);

   p_flt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flt_q && !(rd_en && addr == ADDR_W'(8)) && !alarm_rd_stb
       && !chip_reset && !rst_req) |=> tx_flt_q);

   p_rxflt_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bad && !chip_reset && !rst_req) |=> rx_flt_q);

   p_lf_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(1)) |=> rd_data[7] == $past(tx_flt_q | rx_flt_q));
endmodule

bind phyxs_regbank phyxs_regbank_chk #(
   .ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .RST_CYC(RST_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .alarm_rd_stb(alarm_rd_stb),
   .chip_reset(chip_reset), .loopback_en(loopback_en), .tx_bad(tx_bad),
   .rx_bad(rx_bad), .tx_up_q(tx_up_q), .tx_flt_q(tx_flt_q), .rx_flt_q(rx_flt_q)
);

// File: tb/phyxs_regbank_test.sv
module phyxs_regbank_test;
   localparam int AW = 16;
   localparam int NL = 4;

   typedef struct packed {
      logic        rd, wr, alm;
      logic [3:0]  adr;
      logic [15:0] wd;
      logic        sg, bs, al, pl;
      logic        ck;
      logic [15:0] ex;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VEC [0:NV-1] = '{
      '{1'b1,1'b0,1'b0,4'h0,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h2040,4'd1}, // R1
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0004,4'd1}, // R1
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h8000,4'd7}, // R7
      '{1'b0,1'b1,1'b0,4'h0,16'h7FFF,1'b1,1'b1,1'b1,1'b1,1'b0,16'h0000,4'd3},
      '{1'b1,1'b0,1'b0,4'h0,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h6040,4'd4}, // R4
      '{1'b0,1'b1,1'b0,4'h1,16'hFFFF,1'b1,1'b1,1'b1,1'b1,1'b0,16'h0000,4'd4},
      '{1'b0,1'b1,1'b0,4'h8,16'h3CFF,1'b1,1'b1,1'b1,1'b1,1'b0,16'h0000,4'd4},
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0004,4'd4}, // R4
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h8000,4'd4}, // R4
      '{1'b0,1'b0,1'b0,4'h0,16'h0000,1'b0,1'b1,1'b1,1'b1,1'b0,16'h0000,4'd5},
      '{1'b0,1'b0,1'b0,4'h0,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b0,16'h0000,4'd5},
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0080,4'd5}, // R5
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0084,4'd5}, // R5
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h8800,4'd8}, // R8
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h8000,4'd9}, // R9
      '{1'b0,1'b0,1'b0,4'h0,16'h0000,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0000,4'd8},
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b0,1'b1,16'h8400,4'd10},// R10
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h8400,4'd9}, // R9
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h8000,4'd9}, // R9
      '{1'b0,1'b0,1'b0,4'h0,16'h0000,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0000,4'd9},
      '{1'b0,1'b0,1'b1,4'h0,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b0,16'h0000,4'd9},
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h8000,4'd9}, // R9
      '{1'b0,1'b0,1'b0,4'h0,16'h0000,1'b1,1'b1,1'b0,1'b1,1'b0,16'h0000,4'd5},
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b0,1'b1,1'b1,16'h0080,4'd5}, // R5
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0080,4'd5}, // R5
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0084,4'd6}, // R6
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h8800,4'd8}, // R8
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0004,4'd6}, // R6
      '{1'b1,1'b0,1'b0,4'h5,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0000,4'd10},// R10
      '{1'b0,1'b0,1'b0,4'h0,16'h0000,1'b1,1'b0,1'b1,1'b1,1'b0,16'h0000,4'd8},
      '{1'b1,1'b0,1'b0,4'h8,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h8800,4'd8}, // R8
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0000,4'd6}, // R6
      '{1'b1,1'b0,1'b0,4'h1,16'h0000,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0004,4'd5}  // R5
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0, alarm_rd_stb = 1'b0;
   logic [15:0]   wr_data = '0;
   logic [15:0]   rd_data;
   logic [NL-1:0] sig_ok = '1, byte_sync = '1;
   logic          lane_align = 1'b1, pll_locked = 1'b1;
   logic          chip_reset;
   logic [NL-1:0] loopback_en;
   int            checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   phyxs_regbank #(.ADDR_W(AW), .NUM_LANES(NL), .RST_CYC(4)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .alarm_rd_stb(alarm_rd_stb),
      .sig_ok(sig_ok), .byte_sync(byte_sync), .lane_align(lane_align),
      .pll_locked(pll_locked), .chip_reset(chip_reset), .loopback_en(loopback_en)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic w, input logic a, input logic [3:0] ad,
                        input logic [15:0] d);
      rd_en = r; wr_en = w; alarm_rd_stb = a; addr = AW'(ad); wr_data = d;
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 20000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({15'd0, chip_reset}, 16'd0, "R1 chip_reset");
      chk({12'd0, loopback_en}, 16'd0, "R1 loopback_en");
      chk(rd_data, 16'h0000, "R1 rd_data");

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].rd, VEC[i].wr, VEC[i].alm, VEC[i].adr, VEC[i].wd);
         sig_ok     = VEC[i].sg ? '1 : 4'b1011;
         byte_sync  = VEC[i].bs ? '1 : 4'b1110;
         lane_align = VEC[i].al;
         pll_locked = VEC[i].pl;
         step();
         if (VEC[i].ck) chk(rd_data, VEC[i].ex, $sformatf("R%0d vector %0d", VEC[i].rq, i));
      end
      drive(0, 0, 0, 0, 0);
      sig_ok = '1; byte_sync = '1; lane_align = 1'b1; pll_locked = 1'b1;

      // R3: loopback drives all lanes
      drive(0, 1, 0, 4'h0, 16'h4000); step();
      drive(0, 0, 0, 0, 0);
      chk({12'd0, loopback_en}, 16'h000F, "R3 loopback on");
      drive(1, 0, 0, 4'h0, 0); step();
      chk(rd_data, 16'h6040, "R3 readback");

      // set a fault before the soft reset
      drive(0, 0, 0, 0, 0); pll_locked = 1'b0; step();
      pll_locked = 1'b1;

      // R2: self-clearing reset pulse
      drive(0, 1, 0, 4'h0, 16'hC000); step();
      for (int k = 0; k < 5; k++) begin
         chk({15'd0, chip_reset}, (k < 4) ? 16'd1 : 16'd0, $sformatf("R2 pulse sample %0d", k));
         if (k == 1) chk(rd_data, 16'hA040, "R2 busy readback");
         if (k < 4) chk({12'd0, loopback_en}, 16'd0, "R2 loopback cleared");
         if (k == 0) drive(1, 0, 0, 4'h0, 0); else drive(0, 0, 0, 0, 0);
         step();
      end
      drive(1, 0, 0, 4'h8, 0); step();
      chk(rd_data, 16'h8000, "R2 faults cleared");
      drive(1, 0, 0, 4'h1, 0); step();
      chk(rd_data, 16'h0004, "R2 link up restored");
      drive(1, 0, 0, 4'h0, 0); step();
      chk(rd_data, 16'h2040, "R2 control default");
      drive(0, 0, 0, 0, 0); step();
      chk(rd_data, 16'h2040, "R10 hold between reads");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule